// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of up to 32 transfers on its own, with no processor involvement between them. Software fills a transmit table and a per-entry command table over a simple register bus. It then sets the index of the last entry to run and writes a start bit. The engine shifts entry 0 through the chosen last entry in order, and stores each received word in a receive table. When the last entry is finished, it drops the start bit and raises a finished flag. Software detects completion by polling either of these.

Each command byte selects the chip-select pattern that is driven while its entry is shifted. It also decides whether that pattern runs straight into the next entry or is released for one cycle first. Clock polarity, clock phase, the divisor for the shift clock, the word length, and the delays before and after each word are register fields. They are read by the engine while it runs.

Top module: `qspi_master`

## Requirements
- R1: Three tables of QDEPTH entries can be written and read over the bus. The bus address bits [6:5] select the region: 01 is the transmit table (16-bit), 10 is the receive table (16-bit) and 11 is the command table (8-bit, reads back zero in bits [15:8]). Address bits [4:0] select the entry.
- R2: Region 00 holds the registers at offsets 0..4 in address bits [2:0], and all of them reset to zero. Offset 0 is the mode register: bit 15 master, bits [13:10] word length, bit 9 clock polarity, bit 8 clock phase, bits [7:0] divisor. Offset 1 holds bit 15 start/busy, bits [14:8] pre-delay and bits [7:0] post-delay. Offset 2 holds the last-entry index in bits [12:8]. Offset 3 is 8 bits of plain storage. Offset 4 is status. After reset the chip selects sit at CS_IDLE and SCK is low.
- R3: Writing 1 to offset 1 bit 15 while the master bit is 1 sets the busy bit. Entries then run from 0 up to the last-entry index in order. Busy clears on the edge that ends the last entry's final post-delay cycle, and the finished flag (status bit 7) sets on that same edge.
- R4: The cycle after the start write is idle. Each entry then spends (pre-delay + 1) cycles with its pattern driven and SCK idle, then 2 × divisor × word-length cycles shifting, then (post-delay + 1) cycles with SCK idle.
- R5: An entry whose command bit 7 is 1 is followed directly by the next entry's pre-delay. When bit 7 is 0, one cycle with the chip selects at CS_IDLE separates the two entries. After the last entry the chip selects return to CS_IDLE whatever bit 7 holds. Command bits [3:0] give the driven pattern.
- R6: SCK rests at the clock polarity. Each bit has a first half at polarity XOR phase and a second half at its inverse. Each half lasts the divisor in cycles, and a divisor of 0 acts as 1.
- R7: MOSI carries the word MSB first over the word length, where a length field of 0 means 16 bits. Each bit is held for the whole bit time, and MOSI is 0 outside shifting. MISO is sampled at the end of each first half. The received bits are stored right-justified, with zeros above, in the receive entry of the same index.
- R8: Status bits [4:0] give the index of the last entry executed. Bits 7 and 6 clear when 1 is written to them, and writing 0 leaves them unchanged. Bit 5 reads 0.
- R9: A start write while the master bit is 0 leaves busy at 0, runs no transfer and keeps the chip selects idle. It sets the mode-fault flag, status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | QW+2 | Register/table address (region in top two bits) |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| spi_sck | output | 1 | Shift clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | NCS | Chip-select pattern |

## Verification
The bench builds the block with its default parameters: 32 queue entries, four chip selects and an all-ones idle pattern. Word length, divisor, polarity, phase and both delays are run-time register fields, so one build covers 16-bit and odd-length words, a zero divisor, both clock modes and zero or non-zero delays. Because a full 32-entry queue at divisor 1 is short, the last-entry index can be taken to its top value, and entries with and without chip-select continuation can be interleaved within one run.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int WORD_W = 16;
  localparam int CMD_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_SHIFT = 3'd2,
    ST_POST  = 3'd3,
    ST_GAP   = 3'd4
  } eng_state_t;

  localparam logic [1:0] RGN_REGS = 2'd0;
  localparam logic [1:0] RGN_TX   = 2'd1;
  localparam logic [1:0] RGN_RX   = 2'd2;
  localparam logic [1:0] RGN_CMD  = 2'd3;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_RUN  = 3'd1;
  localparam logic [2:0] OFS_END  = 3'd2;
  localparam logic [2:0] OFS_AUX  = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;

  // half-bit length in system clocks; zero behaves as one
  function automatic logic [7:0] eff_div(input logic [7:0] d);
    return (d == 8'd0) ? 8'd1 : d;
  endfunction

  // word length; zero selects a full 16-bit word
  function automatic logic [4:0] eff_bits(input logic [3:0] b);
    return (b == 4'd0) ? 5'd16 : {1'b0, b};
  endfunction

  // SCK level for a given half of a bit
  function automatic logic sck_level(input logic cpol, input logic cpha,
                                     input logic active, input logic second);
    return active ? (cpol ^ cpha ^ second) : cpol;
  endfunction
endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int AW    = 5,
  parameter int NRD   = 1
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [NRD*AW-1:0]    raddr,
  output logic [NRD*WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p*WIDTH +: WIDTH] = mem[raddr[p*AW +: AW]];
  end
endmodule

// File: rtl/qspi_regs.sv
module qspi_regs
  import qspi_pkg::*;
#(
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    ofs,
  input  logic [15:0]   wdata,
  input  logic          done,
  input  logic [QW-1:0] done_idx,
  output logic [15:0]   rdata,
  output logic          master,
  output logic [3:0]    bits_f,
  output logic          cpol,
  output logic          cpha,
  output logic [7:0]    div_f,
  output logic [6:0]    pre_f,
  output logic [7:0]    post_f,
  output logic [QW-1:0] endp,
  output logic          run,
  output logic          fin,
  output logic          modf
);
  logic [15:0]   mode_q;
  logic [14:0]   dly_q;
  logic [QW-1:0] endp_q;
  logic [7:0]    aux_q;
  logic [QW-1:0] last_q;

  wire wr_mode  = wr && (ofs == OFS_MODE);
  wire wr_run   = wr && (ofs == OFS_RUN);
  wire wr_end   = wr && (ofs == OFS_END);
  wire wr_aux   = wr && (ofs == OFS_AUX);
  wire wr_stat  = wr && (ofs == OFS_STAT);
  wire start_req = wr_run && wdata[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dly_q  <= '0;
      endp_q <= '0;
      aux_q  <= '0;
      last_q <= '0;
      run    <= 1'b0;
      fin    <= 1'b0;
      modf   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_run)  dly_q  <= wdata[14:0];
      if (wr_end)  endp_q <= wdata[8 +: QW];
      if (wr_aux)  aux_q  <= wdata[7:0];
      if (done) begin
        run    <= 1'b0;
        fin    <= 1'b1;
        last_q <= done_idx;
      end else begin
        if (start_req && master) run <= 1'b1;
        if (wr_stat && wdata[7]) fin <= 1'b0;
      end
      if (start_req && !master) modf <= 1'b1;
      else if (wr_stat && wdata[6]) modf <= 1'b0;
    end
  end

  assign master = mode_q[15];
  assign bits_f = mode_q[13:10];
  assign cpol   = mode_q[9];
  assign cpha   = mode_q[8];
  assign div_f  = mode_q[7:0];
  assign pre_f  = dly_q[14:8];
  assign post_f = dly_q[7:0];
  assign endp   = endp_q;

  always_comb begin
    case (ofs)
      OFS_MODE: rdata = mode_q;
      OFS_RUN:  rdata = {run, dly_q};
      OFS_END:  rdata = {3'b000, 5'(endp_q), 8'h00};
      OFS_AUX:  rdata = {8'h00, aux_q};
      OFS_STAT: rdata = {8'h00, fin, modf, 1'b0, 5'(last_q)};
      default:  rdata = 16'h0000;
    endcase
  end

  // R9: a start without master rights raises the fault flag and never runs
  assert_modf_on_slave_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !master && !run) |=> (modf && !run));
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int QW  = 5,
  parameter int NCS = 4,
  parameter logic [NCS-1:0] CS_IDLE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [3:0]        bits_f,
  input  logic [7:0]        div_f,
  input  logic [6:0]        pre_f,
  input  logic [7:0]        post_f,
  input  logic [QW-1:0]     endp,
  output logic [QW-1:0]     fetch_idx,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [CMD_W-1:0]  cmd_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NCS-1:0]    cs,
  output logic              rx_we,
  output logic [QW-1:0]     rx_idx,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic [QW-1:0]     last_idx
);
  eng_state_t        st;
  logic [QW-1:0]     idx;
  logic [7:0]        cnt;
  logic [4:0]        bitn;
  logic              half_b;
  logic [WORD_W-1:0] txw;
  logic [WORD_W-1:0] rxsh;
  logic [NCS-1:0]    pat;
  logic              keep;

  // named internal events
  wire [4:0] nbits      = eff_bits(bits_f);
  wire [7:0] divn       = eff_div(div_f);
  wire       cnt_zero   = (cnt == 8'd0);
  wire       in_shift   = (st == ST_SHIFT);
  wire       half_end   = in_shift && cnt_zero;
  wire       sample_evt = half_end && !half_b;
  wire       bit_end    = half_end && half_b;
  wire       bit_last   = (bitn == nbits - 5'd1);
  wire       shift_done = bit_end && bit_last;
  wire       post_end   = (st == ST_POST) && cnt_zero;
  wire       at_tail    = (idx == endp);
  wire       start_evt  = (st == ST_IDLE) && run;
  wire       load_evt   = start_evt || (post_end && !at_tail && keep) || (st == ST_GAP);
  wire [4:0] bsel       = nbits - 5'd1 - bitn;

  assign fetch_idx = (st == ST_IDLE) ? '0 : idx + QW'(1);
  assign mosi      = in_shift ? txw[bsel[3:0]] : 1'b0;
  assign sck       = sck_level(cpol, cpha, in_shift, half_b);
  assign cs        = (st == ST_IDLE || st == ST_GAP) ? CS_IDLE : pat;
  assign rx_we     = shift_done;
  assign rx_idx    = idx;
  assign rx_word   = rxsh;
  assign done      = post_end && at_tail;
  assign last_idx  = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      idx    <= '0;
      cnt    <= '0;
      bitn   <= '0;
      half_b <= 1'b0;
      txw    <= '0;
      rxsh   <= '0;
      pat    <= CS_IDLE;
      keep   <= 1'b0;
    end else if (load_evt) begin
      st   <= ST_PRE;
      idx  <= fetch_idx;
      txw  <= tx_word;
      pat  <= cmd_byte[NCS-1:0];
      keep <= cmd_byte[CMD_W-1];
      cnt  <= {1'b0, pre_f};
      rxsh <= '0;
    end else begin
      case (st)
        ST_PRE: begin
          if (cnt_zero) begin
            st     <= ST_SHIFT;
            cnt    <= divn - 8'd1;
            bitn   <= '0;
            half_b <= 1'b0;
          end else cnt <= cnt - 8'd1;
        end
        ST_SHIFT: begin
          if (sample_evt) begin
            half_b <= 1'b1;
            rxsh   <= {rxsh[WORD_W-2:0], miso};
            cnt    <= divn - 8'd1;
          end else if (bit_end) begin
            half_b <= 1'b0;
            if (bit_last) begin
              st  <= ST_POST;
              cnt <= post_f;
            end else begin
              bitn <= bitn + 5'd1;
              cnt  <= divn - 8'd1;
            end
          end else cnt <= cnt - 8'd1;
        end
        ST_POST: begin
          if (cnt_zero) st <= at_tail ? ST_IDLE : ST_GAP;
          else cnt <= cnt - 8'd1;
        end
        default: ;
      endcase
    end
  end

  // R6: SCK only moves when a half-bit count expires
  assert_sck_edge_on_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shift && $past(st) == ST_SHIFT && sck != $past(sck)) |-> $past(cnt_zero));
  // R7: the bit counter never passes the word length
  assert_bit_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_shift |-> (bitn < nbits));
  // R7: a receive write is followed by the post-delay phase
  assert_rx_then_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |=> (st == ST_POST));
  // R5: the release cycle only follows a post-delay
  assert_gap_after_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> ($past(st) == ST_POST));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int QDEPTH = 32,
  parameter int NCS    = 4,
  parameter logic [NCS-1:0] CS_IDLE = '1,
  localparam int QW = $clog2(QDEPTH),
  localparam int AW = QW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  output logic           spi_sck,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs
);
  wire [1:0]    rgn = bus_addr[AW-1 -: 2];
  wire [QW-1:0] ent = bus_addr[QW-1:0];
  wire [2:0]    ofs = bus_addr[2:0];

  logic          master, cpol, cpha, run, fin, modf, done, rx_we;
  logic [3:0]    bits_f;
  logic [7:0]    div_f, post_f;
  logic [6:0]    pre_f;
  logic [QW-1:0] endp, fetch_idx, rx_idx, last_idx;
  logic [15:0]   reg_rdata;
  logic [WORD_W-1:0] rx_word;
  logic [2*WORD_W-1:0] tx_rd;
  logic [2*CMD_W-1:0]  cmd_rd;
  logic [WORD_W-1:0]   rx_rd;

  qspi_regs #(.QW(QW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr && rgn == RGN_REGS), .ofs(ofs),
    .wdata(bus_wdata), .done(done), .done_idx(last_idx), .rdata(reg_rdata),
    .master(master), .bits_f(bits_f), .cpol(cpol), .cpha(cpha), .div_f(div_f),
    .pre_f(pre_f), .post_f(post_f), .endp(endp), .run(run), .fin(fin), .modf(modf)
  );

  qspi_ram #(.DEPTH(QDEPTH), .WIDTH(WORD_W), .AW(QW), .NRD(2)) u_tx_ram (
    .clk(clk), .we(bus_wr && rgn == RGN_TX), .waddr(ent), .wdata(bus_wdata),
    .raddr({fetch_idx, ent}), .rdata(tx_rd)
  );

  qspi_ram #(.DEPTH(QDEPTH), .WIDTH(CMD_W), .AW(QW), .NRD(2)) u_cmd_ram (
    .clk(clk), .we(bus_wr && rgn == RGN_CMD), .waddr(ent), .wdata(bus_wdata[CMD_W-1:0]),
    .raddr({fetch_idx, ent}), .rdata(cmd_rd)
  );

  // engine write wins over a bus write on the same cycle
  qspi_ram #(.DEPTH(QDEPTH), .WIDTH(WORD_W), .AW(QW), .NRD(1)) u_rx_ram (
    .clk(clk), .we(rx_we || (bus_wr && rgn == RGN_RX)),
    .waddr(rx_we ? rx_idx : ent), .wdata(rx_we ? rx_word : bus_wdata),
    .raddr(ent), .rdata(rx_rd)
  );

  qspi_engine #(.QW(QW), .NCS(NCS), .CS_IDLE(CS_IDLE)) u_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .cpol(cpol), .cpha(cpha), .bits_f(bits_f),
    .div_f(div_f), .pre_f(pre_f), .post_f(post_f), .endp(endp), .fetch_idx(fetch_idx),
    .tx_word(tx_rd[WORD_W +: WORD_W]), .cmd_byte(cmd_rd[CMD_W +: CMD_W]),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .cs(spi_cs), .rx_we(rx_we),
    .rx_idx(rx_idx), .rx_word(rx_word), .done(done), .last_idx(last_idx)
  );

  always_comb begin
    case (rgn)
      RGN_REGS: bus_rdata = reg_rdata;
      RGN_TX:   bus_rdata = tx_rd[WORD_W-1:0];
      RGN_RX:   bus_rdata = rx_rd;
      default:  bus_rdata = {8'h00, cmd_rd[CMD_W-1:0]};
    endcase
  end

  // R3: completion drops busy and raises the finished flag together
  assert_done_clears_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!run && fin));
  // R3: busy only falls because the last entry completed
  assert_run_falls_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(done));
endmodule

// File: tb/tb_qspi_master.sv
module tb_qspi_master;
  localparam int QD = 32;
  localparam logic [3:0] CSI = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  wire  [15:0] bus_rdata;
  logic        miso = 1'b0;
  wire         sck, mosi;
  wire  [3:0]  cs;

  qspi_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] tx_m [QD];
  logic [7:0]  cmd_m [QD];
  logic [15:0] exp_rx [QD];

  typedef struct {bit sck; bit mosi; bit [3:0] cs; bit busy; int smp;} exp_t;
  exp_t sched[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [6:0] a, input logic [15:0] e);
    @(negedge clk);
    bus_addr = a;
    #1 check(tag, bus_rdata, e);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // behavioural model: expand the queue into an expected per-cycle list
  task automatic run_q(input logic [15:0] c0, input int pre, input int post, input int endp);
    bit cpol = c0[9];
    bit cpha = c0[8];
    int nb = (c0[13:10] == 0) ? 16 : int'(c0[13:10]);
    int d  = (c0[7:0] == 0) ? 1 : int'(c0[7:0]);
    wr(7'h00, c0);
    wr(7'h02, 16'(endp << 8));
    for (int e = 0; e <= endp; e++) begin
      wr(7'(32 + e), tx_m[e]);
      wr(7'(96 + e), {8'h00, cmd_m[e]});
      exp_rx[e] = '0;
    end
    sched.delete();
    sched.push_back('{cpol, 1'b0, CSI, 1'b1, 0});
    for (int e = 0; e <= endp; e++) begin
      bit [3:0] p = cmd_m[e][3:0];
      for (int k = 0; k <= pre; k++) sched.push_back('{cpol, 1'b0, p, 1'b1, 0});
      for (int b = 0; b < nb; b++) begin
        bit v = tx_m[e][nb-1-b];
        for (int h = 0; h < d; h++) sched.push_back('{cpol ^ cpha, v, p, 1'b1, (h == d-1) ? e+1 : 0});
        for (int h = 0; h < d; h++) sched.push_back('{~(cpol ^ cpha), v, p, 1'b1, 0});
      end
      for (int k = 0; k <= post; k++) sched.push_back('{cpol, 1'b0, p, 1'b1, 0});
      if (e != endp && !cmd_m[e][7]) sched.push_back('{cpol, 1'b0, CSI, 1'b1, 0});
    end
    sched.push_back('{cpol, 1'b0, CSI, 1'b0, 0});
    @(negedge clk);
    bus_addr = 7'h01;
    bus_wdata = {1'b1, 7'(pre), 8'(post)};
    bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
    for (int i = 0; i < sched.size(); i++) begin
      exp_t s = sched[i];
      @(negedge clk);
      check("R4 R5 R6 R7 cycle compare", {sck, mosi, cs, bus_rdata[15]},
            {s.sck, s.mosi, s.cs, s.busy});
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      miso = lfsr[0];
      if (s.smp > 0) exp_rx[s.smp-1] = {exp_rx[s.smp-1][14:0], miso};
    end
    for (int e = 0; e <= endp; e++) expect_reg("R7 received word", 7'(64 + e), exp_rx[e]);
    expect_reg("R3 R8 status after run", 7'h04, 16'(16'h80 | endp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2: reset state
    for (int r = 0; r < 5; r++) expect_reg("R2 reset register", 7'(r), 16'h0000);
    check("R2 reset chip select", cs, CSI);
    check("R2 reset sck", sck, 1'b0);
    check("R2 reset mosi", mosi, 1'b0);
    // R2: field layout
    wr(7'h00, 16'hA5F3); expect_reg("R2 mode register", 7'h00, 16'hA5F3);
    wr(7'h01, 16'h7F00); expect_reg("R2 delay register", 7'h01, 16'h7F00);
    wr(7'h02, 16'hFFFF); expect_reg("R2 end index field", 7'h02, 16'h1F00);
    wr(7'h03, 16'h12AB); expect_reg("R2 aux register", 7'h03, 16'h00AB);
    // R1: tables
    wr(7'h25, 16'hA5C3); expect_reg("R1 transmit table", 7'h25, 16'hA5C3);
    wr(7'h69, 16'h12F7); expect_reg("R1 command table", 7'h69, 16'h00F7);
    wr(7'h5F, 16'hBEEF); expect_reg("R1 receive table", 7'h5F, 16'hBEEF);

    // three entries, 8 bits, mode 0, continuation on entry 0 only
    tx_m[0] = 16'h00A5; tx_m[1] = 16'h003C; tx_m[2] = 16'h0081;
    cmd_m[0] = 8'h8E; cmd_m[1] = 8'h0D; cmd_m[2] = 8'h07;
    run_q(16'hA002, 1, 2, 2);
    // R8: write-one-to-clear
    wr(7'h04, 16'h0000); expect_reg("R8 zero write keeps flags", 7'h04, 16'h0082);
    wr(7'h04, 16'h0080); expect_reg("R8 finished flag cleared", 7'h04, 16'h0002);

    // R9: start without master
    wr(7'h00, 16'h2002);
    wr(7'h01, 16'h8000);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9 chip select stays idle", cs, CSI);
    end
    expect_reg("R9 busy stays low", 7'h01, 16'h0000);
    expect_reg("R9 mode fault flag", 7'h04, 16'h0042);
    wr(7'h04, 16'h0040); expect_reg("R9 R8 mode fault cleared", 7'h04, 16'h0002);

    // single 16-bit entry, mode 3, divisor 0, no delays
    tx_m[0] = 16'hC35A; cmd_m[0] = 8'h83;
    run_q(16'h8300, 0, 0, 0);
    wr(7'h04, 16'h0080);

    // 5-bit words, phase 1, divisor 3
    tx_m[0] = 16'hFFF6; tx_m[1] = 16'h0013;
    cmd_m[0] = 8'h0B; cmd_m[1] = 8'h86;
    run_q(16'h9503, 3, 1, 1);
    wr(7'h04, 16'h0080);

    // full queue, 4-bit words, divisor 1
    for (int e = 0; e < QD; e++) begin
      tx_m[e] = 16'(e * 7 + 3);
      cmd_m[e] = (e % 2 == 0) ? 8'(8'h80 | (e % 15)) : 8'(e % 15);
    end
    run_q(16'h9001, 0, 0, QD - 1);

    summary();
  end
endmodule